// File: doc/BRIEF.md
# T=0 Character Error and Retry Controller

This block manages character-level error recovery on a half-duplex smart-card serial link. On the receive side it counts characters that arrive with bad parity. When the count reaches a programmable tolerance it raises a sticky parity-error flag, which a status read clears. Under the T=0 protocol, a character with good parity that arrives before the tolerance is reached wipes the running count.

On the transmit side it watches for the card's error signal (NAK) after each character. It then asks the serializer to send the same character again, timed on a half-ETU tick stream measured from the start of the rejected character. The same 3-bit setting sets both the receive tolerance and the transmit retry budget. A setting of zero turns automatic resending off. In that case, a character the host writes again is launched slightly earlier, at 13.5 ETU. Bit serialization and the ETU timebase are supplied from outside.

Top module: `t0_retry_ctrl`

## Requirements
- R1: After reset, `pe_flag`, `tx_err` and `resend_go` are all 0.
- R2: With setting N on `err_limit`, `pe_flag` rises in the cycle after the (N+1)-th bad-parity character (`rx_char`=1, `rx_parity_ok`=0) and not before.
- R3: With `proto_t0`=1, a good-parity character received while the count is below the limit clears the count. With `proto_t0`=0, good characters leave the count unchanged.
- R4: `pe_flag` stays set until a `status_rd` pulse clears it, together with the count. If a limit-reaching bad character arrives in the same cycle as `status_rd`, the flag stays set.
- R5: Bad characters past the limit saturate the count and do not wrap. After a status read, a full N+1 bad characters are needed again.
- R6: Any change of `proto_t0` clears the error count without touching `pe_flag`.
- R7: With N>0, a `nak` after a character start arms an automatic resend. `resend_go` pulses for one cycle, in the cycle after the 30th `half_tick` counted from the character start or from the previous resend.
- R8: At most N automatic resends follow one `tx_start`. A further `nak` sets `tx_err` instead of resending, and `tx_err` holds until `status_rd`.
- R9: With N=0, `nak` produces no automatic resend and no `tx_err`. If `tx_rewrite` has been pulsed, `resend_go` pulses after the 27th `half_tick` since the character start.
- R10: `tx_start` restores the full retry budget and cancels any pending resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_limit | input | 3 | Error tolerance / retry budget setting N |
| proto_t0 | input | 1 | 1 = T=0 protocol, 0 = block protocol |
| rx_char | input | 1 | Strobe: a character has been received |
| rx_parity_ok | input | 1 | Qualifies `rx_char`: parity was correct |
| status_rd | input | 1 | Strobe: host read of the status register |
| tx_start | input | 1 | Strobe: a new transmit character starts |
| nak | input | 1 | Strobe: card signalled an error on the sent character |
| tx_rewrite | input | 1 | Strobe: host rewrote the character (manual resend) |
| half_tick | input | 1 | One pulse per half ETU |
| pe_flag | output | 1 | Sticky parity-error flag |
| tx_err | output | 1 | Sticky retry-exhausted flag |
| resend_go | output | 1 | One-cycle request to start a resend |

## Verification
A status read and the bad character that reaches the limit can land in the same clock cycle. That cycle decides whether the flag is lost. The bench drives `status_rd` together with a limit-reaching bad character and requires `pe_flag` to remain 1. A lone status read in the next cycle must then clear it. The resend timing is judged by a scoreboard that queues the exact cycle in which each `resend_go` is due, and it flags any pulse that arrives unqueued.

// File: rtl/t0r_pkg.sv
package t0r_pkg;
    localparam int CNT_W     = 3;
    localparam int PH_W      = 5;
    localparam int AUTO_HALF = 30;   // 15 ETU in half-ETU ticks
    localparam int MAN_HALF  = 27;   // 13.5 ETU in half-ETU ticks

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_AUTO = 2'd1,
        TX_MAN  = 2'd2
    } tx_wait_e;

    typedef struct packed {
        logic     go;
        logic     err;
    } tx_out_t;

    function automatic logic [PH_W-1:0] ph_sat_inc(input logic [PH_W-1:0] v);
        return (v == {PH_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/t0r_rx_errcnt.sv
module t0r_rx_errcnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] err_limit,
    input  logic             proto_t0,
    input  logic             rx_char,
    input  logic             rx_parity_ok,
    input  logic             status_rd,
    output logic             pe_flag
);
    localparam int W = CNT_W + 1;

    logic [W-1:0] cnt;
    logic [W-1:0] lim;
    logic [W-1:0] cnt_inc;
    logic         proto_q;
    logic         bad, good, hit, proto_chg;

    assign lim       = {1'b0, err_limit} + 1'b1;
    assign cnt_inc   = (cnt >= lim) ? lim : cnt + 1'b1;
    assign bad       = rx_char && !rx_parity_ok;
    assign good      = rx_char && rx_parity_ok;
    assign hit       = bad && (cnt_inc >= lim);
    assign proto_chg = (proto_q != proto_t0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pe_flag <= 1'b0;
            proto_q <= proto_t0;
        end else begin
            proto_q <= proto_t0;
            if (proto_chg)
                cnt <= '0;
            else if (bad)
                cnt <= cnt_inc;
            else if (good && proto_t0 && (cnt < lim))
                cnt <= '0;
            else if (status_rd)
                cnt <= '0;

            if (hit)
                pe_flag <= 1'b1;
            else if (status_rd)
                pe_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/t0r_tx_retry.sv
module t0r_tx_retry
    import t0r_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int PH_W      = 5,
    parameter int AUTO_HALF = 30,
    parameter int MAN_HALF  = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] err_limit,
    input  logic             tx_start,
    input  logic             nak,
    input  logic             tx_rewrite,
    input  logic             half_tick,
    input  logic             status_rd,
    output tx_out_t          tx_out
);
    localparam logic [PH_W-1:0] AUTO_LAST = PH_W'(AUTO_HALF - 1);
    localparam logic [PH_W-1:0] MAN_LAST  = PH_W'(MAN_HALF - 1);

    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] used;
    tx_wait_e         st;
    logic             rw_pend;
    logic             fire_auto, fire_man, fire;
    logic             nak_idle, exhausted;

    assign fire_auto = (st == TX_AUTO) && half_tick && (phase == AUTO_LAST);
    assign fire_man  = (st == TX_MAN) && half_tick && rw_pend && (phase >= MAN_LAST);
    assign fire      = fire_auto || fire_man;
    assign nak_idle  = nak && (st == TX_IDLE) && !tx_start;
    assign exhausted = (err_limit != '0) && (used >= err_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            used    <= '0;
            st      <= TX_IDLE;
            rw_pend <= 1'b0;
            tx_out  <= '0;
        end else begin
            tx_out.go <= fire;
            if (tx_start) begin
                phase   <= '0;
                used    <= '0;
                st      <= TX_IDLE;
                rw_pend <= 1'b0;
            end else if (fire) begin
                phase   <= '0;
                st      <= TX_IDLE;
                rw_pend <= 1'b0;
            end else begin
                if (half_tick)
                    phase <= ph_sat_inc(phase);
                if (tx_rewrite)
                    rw_pend <= 1'b1;
                if (nak_idle) begin
                    if (err_limit == '0) begin
                        st <= TX_MAN;
                    end else if (!exhausted) begin
                        st   <= TX_AUTO;
                        used <= used + 1'b1;
                    end
                end
            end

            if (nak_idle && exhausted)
                tx_out.err <= 1'b1;
            else if (status_rd)
                tx_out.err <= 1'b0;
        end
    end
endmodule

// File: rtl/t0_retry_ctrl.sv
module t0_retry_ctrl
    import t0r_pkg::*;
#(
    parameter int N_W       = CNT_W,
    parameter int P_W       = PH_W,
    parameter int AUTO_TICK = AUTO_HALF,
    parameter int MAN_TICK  = MAN_HALF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] err_limit,
    input  logic           proto_t0,
    input  logic           rx_char,
    input  logic           rx_parity_ok,
    input  logic           status_rd,
    input  logic           tx_start,
    input  logic           nak,
    input  logic           tx_rewrite,
    input  logic           half_tick,
    output logic           pe_flag,
    output logic           tx_err,
    output logic           resend_go
);
    tx_out_t tx_o;

    t0r_rx_errcnt #(.CNT_W(N_W)) u_rx (
        .clk(clk), .rst(rst), .err_limit(err_limit), .proto_t0(proto_t0),
        .rx_char(rx_char), .rx_parity_ok(rx_parity_ok),
        .status_rd(status_rd), .pe_flag(pe_flag)
    );

    t0r_tx_retry #(.CNT_W(N_W), .PH_W(P_W), .AUTO_HALF(AUTO_TICK), .MAN_HALF(MAN_TICK)) u_tx (
        .clk(clk), .rst(rst), .err_limit(err_limit), .tx_start(tx_start),
        .nak(nak), .tx_rewrite(tx_rewrite), .half_tick(half_tick),
        .status_rd(status_rd), .tx_out(tx_o)
    );

    assign resend_go = tx_o.go;
    assign tx_err    = tx_o.err;
endmodule

// File: rtl/t0_retry_ctrl_chk.sv
module t0_retry_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic rx_char,
    input logic rx_parity_ok,
    input logic status_rd,
    input logic nak,
    input logic half_tick,
    input logic pe_flag,
    input logic tx_err,
    input logic resend_go
);
    // R2: flag can only rise after a bad-parity character
    assert_pe_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pe_flag) |-> $past(rx_char && !rx_parity_ok));

    // R4: a status read with no bad character clears the flag
    assert_rd_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !(rx_char && !rx_parity_ok)) |=> !pe_flag);

    // R8: retry-exhausted flag only rises after a NAK
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_err) |-> $past(nak));

    // R7: resend request follows a half-ETU tick
    assert_go_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(resend_go) |-> $past(half_tick));

    // R7: resend request lasts a single cycle
    assert_go_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        resend_go |=> !resend_go);
endmodule

bind t0_retry_ctrl t0_retry_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_parity_ok(rx_parity_ok),
    .status_rd(status_rd), .nak(nak), .half_tick(half_tick),
    .pe_flag(pe_flag), .tx_err(tx_err), .resend_go(resend_go)
);

// File: tb/t0_retry_ctrl_tb.sv
module t0_retry_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] err_limit = 3'd0;
    logic       proto_t0 = 1'b1;
    logic       rx_char = 1'b0, rx_parity_ok = 1'b0, status_rd = 1'b0;
    logic       tx_start = 1'b0, nak = 1'b0, tx_rewrite = 1'b0, half_tick = 1'b0;
    logic       pe_flag, tx_err, resend_go;

    int n_chk = 0, n_err = 0, cyc = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    t0_retry_ctrl u_dut (
        .clk(clk), .rst(rst), .err_limit(err_limit), .proto_t0(proto_t0),
        .rx_char(rx_char), .rx_parity_ok(rx_parity_ok), .status_rd(status_rd),
        .tx_start(tx_start), .nak(nak), .tx_rewrite(tx_rewrite),
        .half_tick(half_tick), .pe_flag(pe_flag), .tx_err(tx_err),
        .resend_go(resend_go)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the expected cycle of each resend request
    always @(negedge clk) begin
        if (!rst && resend_go) begin
            if (exp_q.size() == 0) chk("R7/R9 unexpected resend_go", cyc, -1);
            else chk("R7/R9 resend_go cycle", cyc, exp_q.pop_front());
        end
    end

    task automatic rx(input logic ok, input logic rd = 1'b0);
        @(negedge clk); rx_char = 1'b1; rx_parity_ok = ok; status_rd = rd;
        @(negedge clk); rx_char = 1'b0; rx_parity_ok = 1'b0; status_rd = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic pulse_start(); @(negedge clk); tx_start = 1'b1; @(negedge clk); tx_start = 1'b0; endtask
    task automatic pulse_nak();   @(negedge clk); nak = 1'b1;      @(negedge clk); nak = 1'b0;      endtask
    task automatic pulse_rw();    @(negedge clk); tx_rewrite = 1'b1; @(negedge clk); tx_rewrite = 1'b0; endtask

    // driver: sends n ticks; pushes the expected resend cycle on tick number mark
    task automatic ticks(input int n, input int mark);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); half_tick = 1'b1;
            @(posedge clk); #1;
            if (i == mark) exp_q.push_back(cyc);
            @(negedge clk); half_tick = 1'b0;
        end
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        chk("R1 pe_flag", pe_flag, 0);
        chk("R1 tx_err", tx_err, 0);
        chk("R1 resend_go", resend_go, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2: setting 7 flags on the 8th bad character
        err_limit = 3'd7;
        for (int i = 0; i < 7; i++) rx(1'b0);
        chk("R2 no flag after 7", pe_flag, 0);
        rx(1'b0);
        chk("R2 flag after 8", pe_flag, 1);
        read_status();
        chk("R4 read clears", pe_flag, 0);

        // R3: T=0 good char clears count
        err_limit = 3'd1;
        rx(1'b0); rx(1'b1); rx(1'b0);
        chk("R3 T=0 good clears", pe_flag, 0);
        rx(1'b0);
        chk("R3 T=0 flag after 2 consecutive", pe_flag, 1);
        chk("R4 sticky", pe_flag, 1);
        read_status();

        // R6: protocol change clears count
        rx(1'b0);
        @(negedge clk); proto_t0 = 1'b0;
        rx(1'b0);
        chk("R6 count cleared by proto change", pe_flag, 0);
        // R3: block protocol keeps count across good char
        rx(1'b1);
        rx(1'b0);
        chk("R3 T=1 good does not clear", pe_flag, 1);
        @(negedge clk); proto_t0 = 1'b1;
        @(negedge clk);
        chk("R6 proto change keeps flag", pe_flag, 1);
        read_status();

        // R5: saturation, restart after read
        rx(1'b0); rx(1'b0); rx(1'b0);
        chk("R5 saturated flag", pe_flag, 1);
        read_status();
        rx(1'b0);
        chk("R5 needs full count again", pe_flag, 0);
        rx(1'b0);
        chk("R5 flag after full count", pe_flag, 1);
        read_status();

        // R4: same-cycle read and limit hit -> set wins
        err_limit = 3'd0;
        rx(1'b0, 1'b1);
        chk("R4 set wins over read", pe_flag, 1);
        read_status();
        chk("R4 lone read clears", pe_flag, 0);

        // R7/R8: setting 2, two auto resends then error
        err_limit = 3'd2;
        pulse_start(); pulse_nak();
        ticks(30, 30);
        pulse_nak();
        ticks(30, 30);
        pulse_nak();
        chk("R8 tx_err after budget", tx_err, 1);
        ticks(32, 0);
        chk("R7 scoreboard drained", exp_q.size(), 0);
        chk("R8 tx_err sticky", tx_err, 1);
        read_status();
        chk("R8 read clears tx_err", tx_err, 0);

        // R10: new character restores budget
        pulse_start(); pulse_nak();
        chk("R10 no error after restart", tx_err, 0);
        ticks(30, 30);

        // R9: setting 0, manual rewrite at 27 half ticks
        err_limit = 3'd0;
        pulse_start(); pulse_nak();
        ticks(32, 0);
        chk("R9 no auto resend, no error", tx_err, 0);
        pulse_start(); pulse_nak(); pulse_rw();
        ticks(27, 27);
        ticks(3, 0);
        chk("R9 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule